// File: doc/BRIEF.md
# Ramp-Search Offset and Gain Calibrator

This block finds the correction code for one converter channel by stepping a trim DAC upward one code at a time. A request names one of two trims: offset or gain. When the request is accepted, the block points the channel's input multiplexer at the reference that belongs to that trim. It clears a ramp counter and drives the counter onto that trim's DAC code output. After each DAC step it waits a programmable number of settle cycles and then asks for one conversion. When the conversion-done strobe arrives, it compares the returned sample with the preset target code for that trim. If they are equal, the ramp stops and the current code is latched as the new held value.

Each trim has its own held code. Between calibrations the held codes drive the DAC outputs. A calibration of one trim never disturbs the other trim's code. A run ends in one of two ways. Either a match stores the new code, or the counter reaches its top code without a match. In the second case the old held code comes back and a fail flag is raised.

A target that sits on either endpoint of the converter range could make the loop hunt against a clipped reading. Such a target is refused at once: no run starts, and the fail flag is raised.

Top module: `ramp_calibrator`

## Requirements
- R1: After reset, busy, done and fail are 0, both DAC code outputs are 0 and mux_sel equals SEL_SIGNAL.
- R2: While busy, mux_sel equals SEL_OFFS_REF for an offset run (cal_mode 0) or SEL_GAIN_REF for a gain run (cal_mode 1); while idle it equals SEL_SIGNAL.
- R3: conv_start is a one-cycle pulse that rises exactly settle_cycles+1 clock cycles after the clock edge that loads a new DAC code.
- R4: During a run, the active DAC code starts at 0 and rises by exactly 1 after each mismatching conversion, so a match at code k takes k+1 conversions.
- R5: When adc_data equals the selected target on an adc_done strobe, the current code becomes the held code for that trim, busy falls and done pulses for one cycle with fail 0.
- R6: An offset run leaves gain_code unchanged, and a gain run leaves offs_code unchanged.
- R7: If the comparison at the top code (all ones) also misses, the run ends with done and fail both 1, and the trim's DAC output returns to its previous held code.
- R8: A request whose selected target is 0 or all ones (in ADC_W bits) starts no run. Instead done pulses one cycle later with fail 1, and both codes stay unchanged.
- R9: cal_req is ignored while adc_idle is 0 and while a run is in progress.
- R10: A match at the top code is a success, not a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_req | input | 1 | Calibration request, sampled while idle |
| cal_mode | input | 1 | Trim chosen by a request: 0 offset, 1 gain |
| adc_idle | input | 1 | Converter has no other work; requests need it high |
| settle_cycles | input | SETTLE_W | Wait after each DAC step before a conversion |
| offs_target | input | ADC_W | Expected sample when the offset trim is right |
| gain_target | input | ADC_W | Expected sample when the gain trim is right |
| adc_data | input | ADC_W | Converter sample |
| adc_done | input | 1 | Conversion-done strobe, qualifies adc_data |
| mux_sel | output | SEL_W | Input multiplexer channel |
| conv_start | output | 1 | One-cycle conversion request |
| offs_code | output | CODE_W | Offset trim DAC code |
| gain_code | output | CODE_W | Gain trim DAC code |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run or a refusal |
| fail | output | 1 | Outcome of the last run or refusal; 1 means no code found |

## Verification
The bench builds the block with CODE_W 6, ADC_W 10 and SETTLE_W 4. With a 64-code ramp, the fail path, where the top code is reached without a match, takes only a few hundred cycles. The success at the top code is just as quick to reach. An ADC model in the bench returns a linear function of the active DAC code, with a different slope per trim, so each expected final code is solved from the target by hand. Two settle values, 2 and 5, show that the conversion timing follows the input and is not fixed.

// File: rtl/ramp_calibrator.sv
module ramp_calibrator #(
  parameter int CODE_W       = 8,
  parameter int ADC_W        = 12,
  parameter int SETTLE_W     = 8,
  parameter int SEL_W        = 2,
  parameter int SEL_SIGNAL   = 0,
  parameter int SEL_OFFS_REF = 1,
  parameter int SEL_GAIN_REF = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_req,
  input  logic                cal_mode,
  input  logic                adc_idle,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic [ADC_W-1:0]    offs_target,
  input  logic [ADC_W-1:0]    gain_target,
  input  logic [ADC_W-1:0]    adc_data,
  input  logic                adc_done,
  output logic [SEL_W-1:0]    mux_sel,
  output logic                conv_start,
  output logic [CODE_W-1:0]   offs_code,
  output logic [CODE_W-1:0]   gain_code,
  output logic                busy,
  output logic                done,
  output logic                fail
);

  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
  localparam logic [ADC_W-1:0]  ADC_TOP  = {ADC_W{1'b1}};

  typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_START, ST_WAIT} state_t;

  state_t              state;
  logic                gain_run;
  logic [CODE_W-1:0]   ramp;
  logic [CODE_W-1:0]   offs_held;
  logic [CODE_W-1:0]   gain_held;
  logic [SETTLE_W-1:0] wait_cnt;

  logic [ADC_W-1:0] req_target;
  logic [ADC_W-1:0] run_target;
  logic             accept;
  logic             at_endpoint;
  logic             hit;

  assign req_target  = cal_mode ? gain_target : offs_target;
  assign run_target  = gain_run ? gain_target : offs_target;
  assign accept      = (state == ST_IDLE) && cal_req && adc_idle;
  assign at_endpoint = (req_target == '0) || (req_target == ADC_TOP);
  assign hit         = adc_done && (adc_data == run_target);

  assign busy       = (state != ST_IDLE);
  assign conv_start = (state == ST_START);
  assign mux_sel    = !busy    ? SEL_W'(SEL_SIGNAL) :
                      gain_run ? SEL_W'(SEL_GAIN_REF) : SEL_W'(SEL_OFFS_REF);
  assign offs_code  = (busy && !gain_run) ? ramp : offs_held;
  assign gain_code  = (busy &&  gain_run) ? ramp : gain_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      gain_run  <= 1'b0;
      ramp      <= '0;
      offs_held <= '0;
      gain_held <= '0;
      wait_cnt  <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (at_endpoint) begin
              done <= 1'b1;
              fail <= 1'b1;
            end else begin
              state    <= ST_SETTLE;
              gain_run <= cal_mode;
              ramp     <= '0;
              wait_cnt <= settle_cycles;
              fail     <= 1'b0;
            end
          end
        end
        ST_SETTLE: begin
          if (wait_cnt == '0) state <= ST_START;
          else wait_cnt <= wait_cnt - 1'b1;
        end
        ST_START: state <= ST_WAIT;
        ST_WAIT: begin
          if (hit) begin
            if (gain_run) gain_held <= ramp;
            else          offs_held <= ramp;
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (adc_done) begin
            if (ramp == CODE_TOP) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              fail  <= 1'b1;
            end else begin
              ramp     <= ramp + 1'b1;
              wait_cnt <= settle_cycles;
              state    <= ST_SETTLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ramp_calibrator_chk.sv
module ramp_calibrator_chk #(
  parameter int CODE_W     = 8,
  parameter int SEL_W      = 2,
  parameter int SEL_SIGNAL = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic              conv_start,
  input logic              gain_run,
  input logic [SEL_W-1:0]  mux_sel,
  input logic [CODE_W-1:0] offs_code,
  input logic [CODE_W-1:0] gain_code
);

  localparam logic [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};

  AST_IDLE_MUX: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mux_sel == SEL_W'(SEL_SIGNAL)); // R2

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R3

  AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R3

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && gain_run && gain_code != $past(gain_code))
      |-> gain_code == $past(gain_code) + ONE); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_OFFS_RUN_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !gain_run) |-> $stable(gain_code)); // R6

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done); // R7

endmodule

bind ramp_calibrator ramp_calibrator_chk #(
  .CODE_W(CODE_W), .SEL_W(SEL_W), .SEL_SIGNAL(SEL_SIGNAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
  .conv_start(conv_start), .gain_run(gain_run), .mux_sel(mux_sel),
  .offs_code(offs_code), .gain_code(gain_code)
);

// File: tb/test_ramp_calibrator.sv
module test_ramp_calibrator;
  localparam int CODE_W = 6;
  localparam int ADC_W  = 10;
  localparam int SETTLE_W = 4;
  localparam int SEL_W = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic cal_req = 0, cal_mode = 0, adc_idle = 1;
  logic [SETTLE_W-1:0] settle_cycles = 2;
  logic [ADC_W-1:0] offs_target = 248, gain_target = 350;
  logic [ADC_W-1:0] adc_data = 0;
  logic adc_done = 0;
  logic [SEL_W-1:0] mux_sel;
  logic conv_start, busy, done, fail;
  logic [CODE_W-1:0] offs_code, gain_code;

  int errors = 0, checks = 0, cycles = 0;
  int lat = 0, conv_count = 0, last_code = -1, step_bad = 0;

  ramp_calibrator #(.CODE_W(CODE_W), .ADC_W(ADC_W), .SETTLE_W(SETTLE_W), .SEL_W(SEL_W),
    .SEL_SIGNAL(0), .SEL_OFFS_REF(1), .SEL_GAIN_REF(2)) i_ramp_calibrator (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_mode(cal_mode), .adc_idle(adc_idle),
    .settle_cycles(settle_cycles), .offs_target(offs_target), .gain_target(gain_target),
    .adc_data(adc_data), .adc_done(adc_done), .mux_sel(mux_sel), .conv_start(conv_start),
    .offs_code(offs_code), .gain_code(gain_code), .busy(busy), .done(done), .fail(fail));

  always #5 clk = ~clk;

  // ADC model: offset trim gives 100+4*code, gain trim gives 200+3*code
  always @(posedge clk) begin
    cycles <= cycles + 1;
    adc_done <= 1'b0;
    if (conv_start) begin
      lat <= 3;
      if (last_code >= 0 && int'(mux_sel == 2 ? gain_code : offs_code) != last_code + 1)
        step_bad <= step_bad + 1;
      last_code <= int'(mux_sel == 2 ? gain_code : offs_code);
      conv_count <= conv_count + 1;
    end else if (lat > 1) lat <= lat - 1;
    else if (lat == 1) begin
      lat <= 0;
      adc_done <= 1'b1;
      adc_data <= (mux_sel == 2) ? ADC_W'(200 + 3 * int'(gain_code))
                                 : ADC_W'(100 + 4 * int'(offs_code));
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic pulse_req(input logic mode);
    @(negedge clk); cal_mode = mode; cal_req = 1;
    @(negedge clk); cal_req = 0;
  endtask

  task automatic wait_done(output logic f);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) check("R5 done timeout", 0, 1);
    f = fail;
  endtask

  task automatic run_cal(input string req, input logic mode, input int settle,
                         input int exp_code, input int exp_fail,
                         input int other_code, input int sel_exp);
    logic f;
    int n;
    settle_cycles = SETTLE_W'(settle);
    conv_count = 0; last_code = -1;
    pulse_req(mode);
    check({req, " R2 mux"}, int'(mux_sel), sel_exp);
    check({req, " R2 busy"}, int'(busy), 1);
    n = 0;
    forever begin @(posedge clk); n++; @(negedge clk); if (conv_start || n > 50) break; end
    check({req, " R3 settle"}, n, settle + 2 - 1);
    wait_done(f);
    check({req, " R5/R7 fail"}, int'(f), exp_fail);
    check({req, " R5 code"}, int'(mode ? gain_code : offs_code), exp_code);
    check({req, " R6 other code"}, int'(mode ? offs_code : gain_code), other_code);
    if (!exp_fail) check({req, " R4 conversions"}, conv_count, exp_code + 1);
    check({req, " R4 unit steps"}, step_bad, 0);
    @(negedge clk);
    check({req, " R5 busy low"}, int'(busy), 0);
    check({req, " R2 mux idle"}, int'(mux_sel), 0);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 fail", int'(fail), 0);
    check("R1 offs", int'(offs_code), 0);
    check("R1 gain", int'(gain_code), 0);
    check("R1 mux", int'(mux_sel), 0);
  endtask

  task automatic t_endpoint(input int tgt);
    logic f;
    offs_target = ADC_W'(tgt);
    pulse_req(0);
    check("R8 no busy", int'(busy), 0);
    check("R8 done", int'(done), 1);
    f = fail;
    check("R8 fail", int'(f), 1);
    check("R8 offs kept", int'(offs_code), 37);
    check("R8 gain kept", int'(gain_code), 63);
    @(negedge clk);
    check("R8 done pulse", int'(done), 0);
  endtask

  task automatic t_ignore();
    logic seen = 0;
    adc_idle = 0; offs_target = 100;
    pulse_req(0);
    repeat (10) begin @(negedge clk); if (busy || done) seen = 1; end
    check("R9 ignored when converter busy", int'(seen), 0);
    check("R9 offs kept", int'(offs_code), 37);
    adc_idle = 1;
    gain_target = 350; settle_cycles = 1;
    pulse_req(1);
    repeat (4) @(negedge clk);
    pulse_req(0);
    check("R9 mux still gain", int'(mux_sel), 2);
    wait_done(seen);
    check("R9 gain result", int'(gain_code), 50);
    check("R9 offs untouched", int'(offs_code), 37);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    offs_target = 100;
    run_cal("zero match", 0, 2, 0, 0, 0, 1);
    offs_target = 248;
    run_cal("offset", 0, 2, 37, 0, 0, 1);
    gain_target = 350;
    run_cal("gain", 1, 5, 50, 0, 37, 2);
    offs_target = 101;
    run_cal("R7 no match", 0, 0, 37, 1, 50, 1);
    gain_target = 389;
    run_cal("R10 top match", 1, 1, 63, 0, 37, 2);
    t_endpoint(0);
    t_endpoint(1023);
    t_ignore();
    finish_run();
  end

  initial begin
    #10;
    rst_n = 0;
    #30 rst_n = 1;
  end

  initial begin
    wait (cycles > 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish_run();
  end
endmodule